// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the purely combinational hazard logic of a short in-order RV32I pipeline. It makes four kinds of decision.

- **Operand bypass.** It picks, for each of the two EX-stage source operands, either the register-file value or the result being written back. It then supplies the chosen operand, with register zero always reading as zero.
- **Load-use stall.** It raises a stall when the instruction in decode needs a value that a load in EX has not yet fetched.
- **Flush.** It asks for the younger stages to be flushed when a branch is taken, a jump retires or a trap is raised.
- **Store-to-load forwarding.** It checks whether a load can be served from the store buffer's single pending entry rather than from memory.

The stall output is meant to be wired to three places: the PC hold, the IF/ID hold and the EX bubble insertion. Store-to-load forwarding compares word addresses and then works at byte-lane level. The load is satisfied only if every byte it reads is covered by a strobe of the buffered store. The forwarded bytes come out right-justified and zero-extended, so sign extension stays with the load unit.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: `wb_wr_en` is 1 exactly when `wb_regwrite` is 1 and `wb_rd` is not zero.
- R2: `fwd_rs1_sel` (and `fwd_rs2_sel`) is 1 exactly when `wb_wr_en` is 1 and `wb_rd` equals `ex_rs1` (respectively `ex_rs2`). A source address of zero therefore never selects the bypass.
- R3: `ex_op1`/`ex_op2` is 0 when the source address is zero. Otherwise it is `wb_data` when the matching select is 1, and the register-file value when the select is 0.
- R4: `stall` is 1 exactly when `ex_is_load` is 1, `ex_rd` is not zero, and `ex_rd` equals `id_rs1` or `id_rs2`.
- R5: `flush` is the OR of `branch_taken`, `jump` and `trap`. It is 0 when all three are 0.
- R6: `stld_hit` is 1 only when all of the following hold:
  - `st_valid` and `ld_valid` are both 1;
  - address bits [31:2] of the store and of the load are equal;
  - the load is naturally aligned;
  - every byte lane the load reads has its `st_strb` bit set.

  The load size codes are: 0 = byte, 1 = halfword, 2 = word, 3 = reserved (never hits). Bit i of `st_strb` covers byte lane i, and lane i is address offset i within the word.
- R7: On a hit, `stld_data` holds the store bytes starting at the load's byte offset, right-justified. Bytes above the load size are zero. On a miss, `stld_data` is 0.
- R8: A byte load one lane above a byte-wide store in the same word does not hit.
- R9: A halfword load at an odd offset, a word load at a non-zero offset, and the reserved size code never hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | Decode-stage source 1 address |
| id_rs2 | input | 5 | Decode-stage source 2 address |
| ex_rs1 | input | 5 | EX-stage source 1 address |
| ex_rs2 | input | 5 | EX-stage source 2 address |
| ex_rd | input | 5 | EX-stage destination address |
| ex_is_load | input | 1 | Instruction in EX is a load |
| wb_rd | input | 5 | Write-back destination address |
| wb_regwrite | input | 1 | Write-back register-write control |
| wb_data | input | 32 | Write-back result |
| rf_rs1_data | input | 32 | Register-file read for EX source 1 |
| rf_rs2_data | input | 32 | Register-file read for EX source 2 |
| branch_taken | input | 1 | Branch resolved taken |
| jump | input | 1 | Jump resolved |
| trap | input | 1 | Trap raised |
| st_valid | input | 1 | Buffered store present and forwarding enabled |
| st_addr | input | 32 | Buffered store byte address |
| st_strb | input | 4 | Buffered store byte strobes |
| st_data | input | 32 | Buffered store data, lane-aligned |
| ld_valid | input | 1 | A load is looking up the store buffer |
| ld_addr | input | 32 | Load byte address |
| ld_size | input | 2 | Load size code |
| wb_wr_en | output | 1 | Effective register-file write enable |
| fwd_rs1_sel | output | 1 | EX source 1 takes the write-back bypass |
| fwd_rs2_sel | output | 1 | EX source 2 takes the write-back bypass |
| ex_op1 | output | 32 | Resolved EX operand 1 |
| ex_op2 | output | 32 | Resolved EX operand 2 |
| stall | output | 1 | Load-use stall: hold PC and IF/ID, bubble EX |
| flush | output | 1 | Flush younger stages |
| stld_hit | output | 1 | Load served from buffered store |
| stld_data | output | 32 | Forwarded load data, zero-extended |

## Verification
The checker assumes that `st_data` is already placed in byte lanes that match `st_strb`. It also assumes that the register-file value for source zero is irrelevant, because the block forces zero whatever that value is. The stimulus never relies on a misaligned load being served: such loads are only probed in order to see them miss. The bench drives the register-file inputs with non-zero patterns that are distinct from `wb_data`, so a wrong operand source or a missing zero-force shows up at `ex_op1`/`ex_op2`.

// File: rtl/hz_ctrl_pkg.sv
// Shared constants for the hazard and forwarding control block.
// Assumes byte-addressed memory with byte strobes, lane i = offset i.
package hz_ctrl_pkg;
    // Load size codes seen on ld_size.
    localparam logic [1:0] LDSZ_BYTE = 2'd0;
    localparam logic [1:0] LDSZ_HALF = 2'd1;
    localparam logic [1:0] LDSZ_WORD = 2'd2;

    // Operand source chosen by one bypass lane.
    typedef enum logic {
        OPSRC_RF = 1'b0,
        OPSRC_WB = 1'b1
    } opsrc_e;
endpackage

// File: rtl/hz_bypass_lane.sv
// One EX operand lane: decides whether the write-back result is bypassed
// into this source and produces the resolved operand value.
// Assumes wb_wr_en already excludes destination zero.
module hz_bypass_lane
    import hz_ctrl_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input  logic [RAW-1:0]  ex_rs,
    input  logic [RAW-1:0]  wb_rd,
    input  logic            wb_wr_en,
    input  logic [XLEN-1:0] rf_data,
    input  logic [XLEN-1:0] wb_data,
    output logic            sel,
    output logic [XLEN-1:0] op
);
    opsrc_e src;

    // Pick the source: bypass only on an enabled, matching write-back.
    always_comb begin
        src = OPSRC_RF;
        if (wb_wr_en && (wb_rd == ex_rs) && (ex_rs != '0))
            src = OPSRC_WB;
    end

    // Resolve the operand value; register zero always reads zero.
    always_comb begin
        if (ex_rs == '0)
            op = '0;
        else if (src == OPSRC_WB)
            op = wb_data;
        else
            op = rf_data;
    end

    assign sel = (src == OPSRC_WB);
endmodule

// File: rtl/hz_loaduse.sv
// Load-use detector: flags a decode instruction that reads the destination
// of a load still in EX. Assumes ex_rd is meaningful only with ex_is_load.
module hz_loaduse #(
    parameter int RAW = 5
) (
    input  logic [RAW-1:0] id_rs1,
    input  logic [RAW-1:0] id_rs2,
    input  logic [RAW-1:0] ex_rd,
    input  logic           ex_is_load,
    output logic           stall
);
    logic hit_a, hit_b;

    // Compare the load destination against both decode sources.
    always_comb begin
        hit_a = (ex_rd == id_rs1);
        hit_b = (ex_rd == id_rs2);
        stall = ex_is_load && (ex_rd != '0) && (hit_a || hit_b);
    end
endmodule

// File: rtl/hz_stld_match.sv
// Store-to-load matcher for a single buffered store entry. Checks the word
// address, the natural alignment of the load and byte-strobe coverage, and
// returns the selected bytes right-justified and zero-extended.
// Assumes st_data is lane-aligned with st_strb.
module hz_stld_match #(
    parameter int XLEN = 32
) (
    input  logic              st_valid,
    input  logic [XLEN-1:0]   st_addr,
    input  logic [XLEN/8-1:0] st_strb,
    input  logic [XLEN-1:0]   st_data,
    input  logic              ld_valid,
    input  logic [XLEN-1:0]   ld_addr,
    input  logic [1:0]        ld_size,
    output logic              hit,
    output logic [XLEN-1:0]   data
);
    localparam int NB   = XLEN / 8;
    localparam int OFFW = $clog2(NB);

    logic [OFFW-1:0] off;
    logic [NB-1:0]   need;
    logic            size_ok, aligned, word_eq, covered;
    logic [XLEN-1:0] shifted, trimmed;
    int              nbytes;

    assign off     = ld_addr[OFFW-1:0];
    assign word_eq = (st_addr[XLEN-1:OFFW] == ld_addr[XLEN-1:OFFW]);

    // Derive the load's byte span, its alignment and the lanes it reads.
    always_comb begin
        size_ok = (int'(ld_size) <= OFFW);
        nbytes  = 1 << int'(ld_size);
        aligned = size_ok && ((int'(off) % nbytes) == 0);
        for (int i = 0; i < NB; i++)
            need[i] = size_ok && (i >= int'(off)) && (i < int'(off) + nbytes);
        covered = ((need & ~st_strb) == '0);
    end

    // Right-justify the store bytes and zero the lanes beyond the load size.
    always_comb begin
        shifted = st_data >> {off, 3'b000};
        for (int i = 0; i < NB; i++)
            trimmed[i*8 +: 8] = (i < nbytes) ? shifted[i*8 +: 8] : 8'h00;
    end

    assign hit  = st_valid && ld_valid && word_eq && aligned && covered;
    assign data = hit ? trimmed : '0;
endmodule

// File: rtl/pipe_hazard_ctrl.sv
// Hazard and forwarding control for a short in-order pipeline: write-back
// enable, per-operand bypass, load-use stall, flush and store-to-load
// forwarding. Purely combinational; stall drives PC hold, IF/ID hold and
// EX bubble outside this block.
module pipe_hazard_ctrl #(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input  logic [RAW-1:0]    id_rs1,
    input  logic [RAW-1:0]    id_rs2,
    input  logic [RAW-1:0]    ex_rs1,
    input  logic [RAW-1:0]    ex_rs2,
    input  logic [RAW-1:0]    ex_rd,
    input  logic              ex_is_load,
    input  logic [RAW-1:0]    wb_rd,
    input  logic              wb_regwrite,
    input  logic [XLEN-1:0]   wb_data,
    input  logic [XLEN-1:0]   rf_rs1_data,
    input  logic [XLEN-1:0]   rf_rs2_data,
    input  logic              branch_taken,
    input  logic              jump,
    input  logic              trap,
    input  logic              st_valid,
    input  logic [XLEN-1:0]   st_addr,
    input  logic [XLEN/8-1:0] st_strb,
    input  logic [XLEN-1:0]   st_data,
    input  logic              ld_valid,
    input  logic [XLEN-1:0]   ld_addr,
    input  logic [1:0]        ld_size,
    output logic              wb_wr_en,
    output logic              fwd_rs1_sel,
    output logic              fwd_rs2_sel,
    output logic [XLEN-1:0]   ex_op1,
    output logic [XLEN-1:0]   ex_op2,
    output logic              stall,
    output logic              flush,
    output logic              stld_hit,
    output logic [XLEN-1:0]   stld_data
);
    localparam int NSRC = 2;

    logic [RAW-1:0]  lane_rs  [NSRC];
    logic [XLEN-1:0] lane_rf  [NSRC];
    logic [XLEN-1:0] lane_op  [NSRC];
    logic [NSRC-1:0] lane_sel;

    // Effective write enable: no write for destination zero.
    assign wb_wr_en = wb_regwrite && (wb_rd != '0);

    // Any redirect empties the younger stages; order of causes is irrelevant.
    assign flush = branch_taken | jump | trap;

    assign lane_rs[0] = ex_rs1;
    assign lane_rs[1] = ex_rs2;
    assign lane_rf[0] = rf_rs1_data;
    assign lane_rf[1] = rf_rs2_data;

    for (genvar g = 0; g < NSRC; g++) begin : g_lane
        hz_bypass_lane #(.XLEN(XLEN), .RAW(RAW)) u_lane (
            .ex_rs    (lane_rs[g]),
            .wb_rd    (wb_rd),
            .wb_wr_en (wb_wr_en),
            .rf_data  (lane_rf[g]),
            .wb_data  (wb_data),
            .sel      (lane_sel[g]),
            .op       (lane_op[g])
        );
    end

    assign fwd_rs1_sel = lane_sel[0];
    assign fwd_rs2_sel = lane_sel[1];
    assign ex_op1      = lane_op[0];
    assign ex_op2      = lane_op[1];

    hz_loaduse #(.RAW(RAW)) u_loaduse (
        .id_rs1     (id_rs1),
        .id_rs2     (id_rs2),
        .ex_rd      (ex_rd),
        .ex_is_load (ex_is_load),
        .stall      (stall)
    );

    hz_stld_match #(.XLEN(XLEN)) u_stld (
        .st_valid (st_valid),
        .st_addr  (st_addr),
        .st_strb  (st_strb),
        .st_data  (st_data),
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .ld_size  (ld_size),
        .hit      (stld_hit),
        .data     (stld_data)
    );
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
// Checker for pipe_hazard_ctrl: immediate assertions on the settled
// combinational outputs, relating them back to the stage inputs.
module pipe_hazard_ctrl_chk #(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input logic [RAW-1:0]  ex_rs1,
    input logic [RAW-1:0]  ex_rs2,
    input logic [RAW-1:0]  ex_rd,
    input logic            ex_is_load,
    input logic [RAW-1:0]  wb_rd,
    input logic            wb_regwrite,
    input logic [XLEN-1:0] wb_data,
    input logic            branch_taken,
    input logic            jump,
    input logic            trap,
    input logic            st_valid,
    input logic [XLEN-1:0] st_addr,
    input logic            ld_valid,
    input logic [XLEN-1:0] ld_addr,
    input logic            wb_wr_en,
    input logic            fwd_rs1_sel,
    input logic            fwd_rs2_sel,
    input logic [XLEN-1:0] ex_op1,
    input logic [XLEN-1:0] ex_op2,
    input logic            stall,
    input logic            flush,
    input logic            stld_hit,
    input logic [XLEN-1:0] stld_data
);
    localparam int OFFW = $clog2(XLEN / 8);

    // Check each output against its causes whenever inputs settle.
    always_comb begin
        if (wb_wr_en)
            a_r1_wben_needs_write: assert (wb_regwrite && wb_rd != '0);
        if (fwd_rs1_sel)
            a_r2_fwd1_valid: assert (ex_rs1 != '0 && wb_wr_en && wb_rd == ex_rs1);
        if (fwd_rs2_sel)
            a_r2_fwd2_valid: assert (ex_rs2 != '0 && wb_wr_en && wb_rd == ex_rs2);
        if (ex_rs1 == '0)
            a_r3_op1_x0_zero: assert (ex_op1 == '0);
        if (ex_rs2 == '0)
            a_r3_op2_x0_zero: assert (ex_op2 == '0);
        if (fwd_rs1_sel)
            a_r3_op1_bypass_value: assert (ex_op1 == wb_data);
        if (fwd_rs2_sel)
            a_r3_op2_bypass_value: assert (ex_op2 == wb_data);
        if (stall)
            a_r4_stall_needs_load: assert (ex_is_load && ex_rd != '0);
        if (flush)
            a_r5_flush_has_cause: assert (branch_taken || jump || trap);
        if (stld_hit)
            a_r6_hit_same_word: assert (st_valid && ld_valid &&
                st_addr[XLEN-1:OFFW] == ld_addr[XLEN-1:OFFW]);
        if (!stld_hit)
            a_r7_miss_data_zero: assert (stld_data == '0);
    end
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.XLEN(XLEN), .RAW(RAW)) u_chk (.*);

// File: tb/pipe_hazard_ctrl_tb.sv
// Self-checking bench: a vector table for bypass, stall and flush, then
// directed probes of the store-to-load matcher.
module pipe_hazard_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RF1 = 32'h1111_1111;
    localparam logic [31:0] RF2 = 32'h2222_2222;
    localparam logic [31:0] WBV = 32'hABCD_0001;
    localparam logic [31:0] SDATA = 32'h8877_6655;

    typedef struct packed {
        logic [4:0] id1, id2, ex1, ex2, exrd;
        logic       ld;
        logic [4:0] wbrd;
        logic       wbw, br, jp, tr;
        logic       e_wben, e_f1, e_f2, e_st, e_fl;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{5'd0, 5'd0, 5'd5, 5'd6, 5'd0, 1'b0, 5'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{5'd0, 5'd0, 5'd5, 5'd6, 5'd0, 1'b0, 5'd6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{5'd0, 5'd0, 5'd5, 5'd6, 5'd0, 1'b0, 5'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{5'd0, 5'd0, 5'd7, 5'd7, 5'd0, 1'b0, 5'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{5'd3, 5'd4, 5'd1, 5'd2, 5'd3, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{5'd3, 5'd4, 5'd1, 5'd2, 5'd4, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{5'd3, 5'd4, 5'd1, 5'd2, 5'd4, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{5'd0, 5'd0, 5'd1, 5'd2, 5'd0, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{5'd3, 5'd4, 5'd1, 5'd2, 5'd9, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic [4:0]  id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, wb_rd;
    logic        ex_is_load, wb_regwrite, branch_taken, jump, trap;
    logic [31:0] wb_data, rf_rs1_data, rf_rs2_data;
    logic        st_valid, ld_valid;
    logic [31:0] st_addr, st_data, ld_addr;
    logic [3:0]  st_strb;
    logic [1:0]  ld_size;
    logic        wb_wr_en, fwd_rs1_sel, fwd_rs2_sel, stall, flush, stld_hit;
    logic [31:0] ex_op1, ex_op2, stld_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pipe_hazard_ctrl u_dut (.*);

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Drive one store/load pair and check hit and data (R6, R7).
    task automatic probe(input string tag, input logic sv, input logic [31:0] sa,
                         input logic [3:0] sb, input logic lv, input logic [31:0] la,
                         input logic [1:0] lsz, input logic eh, input logic [31:0] ed);
        @(posedge clk);
        st_valid = sv; st_addr = sa; st_strb = sb; st_data = SDATA;
        ld_valid = lv; ld_addr = la; ld_size = lsz;
        @(negedge clk);
        chk1({tag, " hit"}, stld_hit, eh);
        chk32({tag, " data"}, stld_data, ed);
    endtask

    initial begin
        id_rs1 = '0; id_rs2 = '0; ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0; wb_rd = '0;
        ex_is_load = 1'b0; wb_regwrite = 1'b0; branch_taken = 1'b0; jump = 1'b0; trap = 1'b0;
        wb_data = WBV; rf_rs1_data = RF1; rf_rs2_data = RF2;
        st_valid = 1'b0; ld_valid = 1'b0; st_addr = '0; st_data = '0; ld_addr = '0;
        st_strb = '0; ld_size = '0;

        // Idle state after start-up: nothing active.
        @(negedge clk);
        chk1("R1 idle wb_wr_en", wb_wr_en, 1'b0);
        chk1("R4 idle stall", stall, 1'b0);
        chk1("R5 idle flush", flush, 1'b0);
        chk1("R6 idle stld_hit", stld_hit, 1'b0);

        // Table walk: bypass, operand value, stall and flush.
        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            id_rs1 = VECS[i].id1; id_rs2 = VECS[i].id2;
            ex_rs1 = VECS[i].ex1; ex_rs2 = VECS[i].ex2; ex_rd = VECS[i].exrd;
            ex_is_load = VECS[i].ld; wb_rd = VECS[i].wbrd; wb_regwrite = VECS[i].wbw;
            branch_taken = VECS[i].br; jump = VECS[i].jp; trap = VECS[i].tr;
            @(negedge clk);
            chk1($sformatf("R1 vec%0d wb_wr_en", i), wb_wr_en, VECS[i].e_wben);
            chk1($sformatf("R2 vec%0d fwd_rs1_sel", i), fwd_rs1_sel, VECS[i].e_f1);
            chk1($sformatf("R2 vec%0d fwd_rs2_sel", i), fwd_rs2_sel, VECS[i].e_f2);
            chk32($sformatf("R3 vec%0d ex_op1", i), ex_op1,
                  (VECS[i].ex1 == 5'd0) ? 32'd0 : (VECS[i].e_f1 ? WBV : RF1));
            chk32($sformatf("R3 vec%0d ex_op2", i), ex_op2,
                  (VECS[i].ex2 == 5'd0) ? 32'd0 : (VECS[i].e_f2 ? WBV : RF2));
            chk1($sformatf("R4 vec%0d stall", i), stall, VECS[i].e_st);
            chk1($sformatf("R5 vec%0d flush", i), flush, VECS[i].e_fl);
        end

        // Store-to-load matcher, full-word store at 0x1000.
        probe("R6 R7 word same", 1'b1, 32'h1000, 4'hF, 1'b1, 32'h1000, 2'd2, 1'b1, 32'h8877_6655);
        probe("R7 byte off2",    1'b1, 32'h1000, 4'hF, 1'b1, 32'h1002, 2'd0, 1'b1, 32'h0000_0077);
        probe("R7 half off2",    1'b1, 32'h1000, 4'hF, 1'b1, 32'h1002, 2'd1, 1'b1, 32'h0000_8877);
        probe("R6 other word",   1'b1, 32'h1000, 4'hF, 1'b1, 32'h1004, 2'd2, 1'b0, 32'h0);
        probe("R6 store off",    1'b0, 32'h1000, 4'hF, 1'b1, 32'h1000, 2'd2, 1'b0, 32'h0);
        probe("R6 load off",     1'b1, 32'h1000, 4'hF, 1'b0, 32'h1000, 2'd2, 1'b0, 32'h0);
        // Partial strobes.
        probe("R8 adjacent byte", 1'b1, 32'h1000, 4'h1, 1'b1, 32'h1001, 2'd0, 1'b0, 32'h0);
        probe("R7 byte lane0",    1'b1, 32'h1000, 4'h1, 1'b1, 32'h1000, 2'd0, 1'b1, 32'h0000_0055);
        probe("R7 half lanes01",  1'b1, 32'h1000, 4'h3, 1'b1, 32'h1000, 2'd1, 1'b1, 32'h0000_6655);
        probe("R6 word partial",  1'b1, 32'h1000, 4'h3, 1'b1, 32'h1000, 2'd2, 1'b0, 32'h0);
        probe("R6 half uncovered", 1'b1, 32'h1000, 4'h3, 1'b1, 32'h1002, 2'd1, 1'b0, 32'h0);
        // Misaligned and reserved sizes.
        probe("R9 half odd",      1'b1, 32'h1000, 4'hF, 1'b1, 32'h1001, 2'd1, 1'b0, 32'h0);
        probe("R9 word off2",     1'b1, 32'h1000, 4'hF, 1'b1, 32'h1002, 2'd2, 1'b0, 32'h0);
        probe("R9 reserved size", 1'b1, 32'h1000, 4'hF, 1'b1, 32'h1000, 2'd3, 1'b0, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule